// File: doc/BRIEF.md
# Scratchpad Staging Buffer with Transfer Status

This block is the 64-byte staging buffer of a serial EEPROM. It receives
already-framed bytes from the bus front end and serves two byte-level
commands. The write command (0Fh) loads a two-byte target address and then
stores data into the buffer. The read command (AAh) returns the target
address, a status byte and the buffered data. Both commands end with an
inverted 16-bit CRC.

The target address sets the buffer offset. Its low six bits select where
data starts. Addresses in the password window are snapped to an 8-byte
boundary. The status byte holds three things: the offset of the last stored
byte, a partial/invalid flag (PF) and a copy-accepted flag (AA). The copy
logic reads the address, the status and the buffer contents through plain
output ports. It raises AA through an input once it has accepted a copy.

Top module: `spad_stage`

## Requirements
- R1: After reset the target address reads 0000h, the status byte reads 00h, `tx_byte` reads FFh, and the first byte after reset is taken as a command code.
- R2: A write command (0Fh) clears AA (status bit 7) and PF (status bit 6). The next byte is the address low byte and the one after it is the high byte. The address becomes visible on `ta_out` when the high byte arrives, with bit 15 forced to 0.
- R3: When the loaded address (after the bit-15 clear) falls in 7FC0h..7FCFh, its bits 2:0 are forced to 0. A write there therefore starts at buffer offset 00h or 08h.
- R4: Loading the high address byte sets the ending offset (status bits 5:0) to the start offset, which is address bits 5:0. Each data byte after that is stored at the current offset, the ending offset takes that offset, and the offset then advances. Once the byte at offset 3Fh is stored, later received bytes are ignored.
- R5: A partial byte received during a write (in either address byte or in the data) sets PF. That byte is discarded and every later byte of the frame is ignored.
- R6: During a write, `tx_byte` reads FFh until the byte at offset 3Fh is stored. After that, two read requests return the inverted CRC low byte and then the inverted high byte. The CRC is reflected CRC16 with polynomial x^16+x^15+x^2+1, started at 0000h, taken over 0Fh, the two address bytes as received, and the data. Further reads return FFh.
- R7: A read command (AAh) returns, one byte per request, the address low byte, the address high byte, the status byte, and then the data from the start offset through 3Fh. It then returns the inverted CRC (low byte first) of AAh and all the bytes it returned, followed by FFh.
- R8: A power-loss pulse sets PF.
- R9: An authorization pulse from the copy logic sets AA. The next write command clears it.
- R10: `frame_start` ends the current command, and the next byte is taken as a command. An unknown command code makes the rest of the frame inert: `tx_byte` stays FFh, and the address and status do not change.
- R11: `cp_data` always shows the buffer byte selected by `cp_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Bus reset seen; next byte is a command |
| rx_valid | input | 1 | A full byte from the master is present |
| rx_byte | input | 8 | Received byte |
| rx_partial | input | 1 | The master sent an incomplete byte |
| tx_req | input | 1 | Master consumed `tx_byte`; advance |
| tx_byte | output | 8 | Byte offered to the master |
| pwr_lost | input | 1 | Supply dropped; buffer contents invalid |
| aa_set | input | 1 | Copy logic accepted authorization |
| ta_out | output | 16 | Target address register |
| es_out | output | 8 | Status: AA, PF, ending offset |
| cp_addr | input | 6 | Buffer index for the copy logic |
| cp_data | output | 8 | Buffer byte at `cp_addr` |

## Verification
The assertions check the following on every cycle:
- a write command clears both flags;
- power loss raises PF;
- an address inside the password window is aligned;
- the status byte stays put during a read stream;
- the ending offset follows the write pointer;
- a read stream moves into its CRC phase after offset 3Fh.

Only the bench scenarios can show the rest. That covers the exact byte streams and their CRC values, writes that start mid-buffer or in the password window, the discarding that follows a partial byte, and the inert frame after an unknown command.

// File: rtl/spad_pkg.sv
package spad_pkg;

  localparam logic [7:0] OP_WRITE  = 8'h0F;
  localparam logic [7:0] OP_READ   = 8'hAA;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  typedef enum logic [3:0] {
    S_CMD, S_IGN, S_WTA1, S_WTA2, S_WDAT,
    S_RTA1, S_RTA2, S_RES, S_RDAT, S_CRC0, S_CRC1
  } sp_state_e;

  // Reflected CRC16, polynomial x^16+x^15+x^2+1, LSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/spad_addr_norm.sv
module spad_addr_norm #(
  parameter int          USER_AW  = 15,
  parameter logic [15:0] PW_BASE  = 16'h7FC0,
  parameter int          PW_BYTES = 16,
  parameter int          PW_ALIGN = 8
) (
  input  logic [15:0] raw,
  output logic [15:0] norm
);
  localparam int          AL     = $clog2(PW_ALIGN);
  localparam logic [15:0] MASK   = 16'((32'h1 << USER_AW) - 1);
  localparam logic [15:0] PW_END = 16'(PW_BASE + PW_BYTES);

  logic [15:0] masked;
  logic        in_pw;

  always_comb begin
    masked = raw & MASK;
    in_pw  = (masked >= PW_BASE) && (masked < PW_END);
    norm   = in_pw ? {masked[15:AL], {AL{1'b0}}} : masked;
  end
endmodule

// File: rtl/spad_crc.sv
module spad_crc
  import spad_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] crc_q, crc_d, base;

  always_comb begin
    base  = clr ? 16'h0000 : crc_q;
    crc_d = crc_q;
    if (upd) crc_d = crc16_step(base, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          crc_q <= 16'h0000;
    else if (upd || clr) crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/spad_mem.sv
module spad_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra0,
  output logic [DW-1:0] rd0,
  input  logic [AW-1:0] ra1,
  output logic [DW-1:0] rd1
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) mem[g] <= wdata;
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/spad_stage.sv
module spad_stage
  import spad_pkg::*;
#(
  parameter int          DEPTH    = 64,
  parameter int          USER_AW  = 15,
  parameter logic [15:0] PW_BASE  = 16'h7FC0,
  parameter int          PW_BYTES = 16,
  parameter int          PW_ALIGN = 8,
  localparam int         OW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_partial,
  input  logic          tx_req,
  output logic [7:0]    tx_byte,
  input  logic          pwr_lost,
  input  logic          aa_set,
  output logic [15:0]   ta_out,
  output logic [OW+1:0] es_out,
  input  logic [OW-1:0] cp_addr,
  output logic [7:0]    cp_data
);
  localparam logic [OW-1:0] LAST = OW'(DEPTH - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      rst_sn <= rst_m;
    end
  end

  sp_state_e     st_q, st_d;
  logic [15:0]   ta_q, ta_d;
  logic [7:0]    ta1_q, ta1_d;
  logic [OW-1:0] off_q, off_d, end_q, end_d;
  logic          aa_q, aa_d, pf_q, pf_d;

  logic          crc_clr, crc_upd;
  logic [7:0]    crc_din;
  logic [15:0]   crc;
  logic          mem_we;
  logic [7:0]    rd_data;
  logic [15:0]   ta_norm;

  spad_addr_norm #(
    .USER_AW(USER_AW), .PW_BASE(PW_BASE), .PW_BYTES(PW_BYTES), .PW_ALIGN(PW_ALIGN)
  ) u_norm (
    .raw ({rx_byte, ta1_q}),
    .norm(ta_norm)
  );

  spad_crc u_crc (
    .clk(clk), .rst_n(rst_sn), .clr(crc_clr), .upd(crc_upd), .din(crc_din), .crc(crc)
  );

  spad_mem #(.DEPTH(DEPTH), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .waddr(off_q), .wdata(rx_byte),
    .ra0(off_q), .rd0(rd_data), .ra1(cp_addr), .rd1(cp_data)
  );

  assign es_out = {aa_q, pf_q, end_q};
  assign ta_out = ta_q;

  // byte offered to the master in each state
  always_comb begin
    case (st_q)
      S_RTA1:  tx_byte = ta_q[7:0];
      S_RTA2:  tx_byte = ta_q[15:8];
      S_RES:   tx_byte = {aa_q, pf_q, end_q};
      S_RDAT:  tx_byte = rd_data;
      S_CRC0:  tx_byte = ~crc[7:0];
      S_CRC1:  tx_byte = ~crc[15:8];
      default: tx_byte = IDLE_BYTE;
    endcase
  end

  // next-state logic
  always_comb begin
    st_d    = st_q;
    ta_d    = ta_q;
    ta1_d   = ta1_q;
    off_d   = off_q;
    end_d   = end_q;
    aa_d    = aa_q;
    pf_d    = pf_q;
    crc_clr = 1'b0;
    crc_upd = 1'b0;
    crc_din = rx_byte;
    mem_we  = 1'b0;

    if (aa_set) aa_d = 1'b1;

    if (frame_start) begin
      st_d = S_CMD;
    end else begin
      case (st_q)
        S_CMD: begin
          if (rx_valid) begin
            if (rx_byte == OP_WRITE) begin
              crc_clr = 1'b1;
              crc_upd = 1'b1;
              aa_d    = 1'b0;
              pf_d    = 1'b0;
              st_d    = S_WTA1;
            end else if (rx_byte == OP_READ) begin
              crc_clr = 1'b1;
              crc_upd = 1'b1;
              st_d    = S_RTA1;
            end else begin
              st_d = S_IGN;
            end
          end else if (rx_partial) begin
            st_d = S_IGN;
          end
        end
        S_WTA1, S_WTA2, S_WDAT: begin
          if (rx_partial) begin
            pf_d = 1'b1;
            st_d = S_IGN;
          end else if (rx_valid) begin
            crc_upd = 1'b1;
            if (st_q == S_WTA1) begin
              ta1_d = rx_byte;
              st_d  = S_WTA2;
            end else if (st_q == S_WTA2) begin
              ta_d  = ta_norm;
              off_d = ta_norm[OW-1:0];
              end_d = ta_norm[OW-1:0];
              st_d  = S_WDAT;
            end else begin
              mem_we = 1'b1;
              end_d  = off_q;
              if (off_q == LAST) st_d = S_CRC0;
              else               off_d = off_q + 1'b1;
            end
          end
        end
        S_RTA1, S_RTA2, S_RES, S_RDAT: begin
          if (tx_req) begin
            crc_upd = 1'b1;
            crc_din = tx_byte;
            case (st_q)
              S_RTA1: st_d = S_RTA2;
              S_RTA2: st_d = S_RES;
              S_RES: begin
                st_d  = S_RDAT;
                off_d = ta_q[OW-1:0];
              end
              default: begin
                if (off_q == LAST) st_d = S_CRC0;
                else               off_d = off_q + 1'b1;
              end
            endcase
          end
        end
        S_CRC0:  if (tx_req) st_d = S_CRC1;
        S_CRC1:  if (tx_req) st_d = S_IGN;
        default: st_d = st_q;
      endcase
    end

    if (pwr_lost) pf_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q  <= S_CMD;
      ta_q  <= '0;
      ta1_q <= '0;
      off_q <= '0;
      end_q <= '0;
      aa_q  <= 1'b0;
      pf_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ta_q  <= ta_d;
      ta1_q <= ta1_d;
      off_q <= off_d;
      end_q <= end_d;
      aa_q  <= aa_d;
      pf_q  <= pf_d;
    end
  end

  // checks next to the logic
  a_r8_pwr_sets_pf: assert property (@(posedge clk) disable iff (!rst_sn)
    pwr_lost |=> pf_q);

  a_r2_write_clears_flags: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == S_CMD && rx_valid && rx_byte == OP_WRITE && !frame_start && !pwr_lost)
      |=> (!aa_q && !pf_q));

  a_r3_pw_aligned: assert property (@(posedge clk) disable iff (!rst_sn)
    (ta_q >= PW_BASE && ta_q < 16'(PW_BASE + PW_BYTES)) |-> (ta_q[2:0] == 3'b000));

  a_r7_status_stable_in_read: assert property (@(posedge clk) disable iff (!rst_sn)
    ((st_q == S_RTA1 || st_q == S_RTA2 || st_q == S_RES || st_q == S_RDAT)
      && !pwr_lost && !aa_set) |=> $stable(es_out));

  a_r4_end_follows_ptr: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == S_WDAT && rx_valid && !rx_partial && !frame_start)
      |=> (end_q == $past(off_q)));

  a_r7_crc_after_last: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == S_RDAT && tx_req && off_q == LAST && !frame_start) |=> (st_q == S_CRC0));

endmodule

// File: tb/sim_spad_stage.sv
module sim_spad_stage;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       frame_start = 1'b0, rx_valid = 1'b0, rx_partial = 1'b0, tx_req = 1'b0;
  logic       pwr_lost = 1'b0, aa_set = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [5:0] cp_addr = 6'd0;
  logic [7:0] tx_byte, cp_data, es_out;
  logic [15:0] ta_out;

  always #4 clk = ~clk;   // 125 MHz

  spad_stage u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_partial(rx_partial), .tx_req(tx_req), .tx_byte(tx_byte),
    .pwr_lost(pwr_lost), .aa_set(aa_set), .ta_out(ta_out), .es_out(es_out),
    .cp_addr(cp_addr), .cp_data(cp_data)
  );

  int vectors = 0, fails = 0;
  bit armed = 0, done = 0;

  // behavioural reference model
  logic [7:0]  m_mem [64];
  bit          m_vld [64];
  logic [15:0] m_ta = 16'h0;
  logic [7:0]  m_ta1 = 8'h0;
  logic [7:0]  m_es = 8'h0;
  int          m_mode = 0;      // 0 cmd, 1 inert, 2 ta1, 3 ta2, 4 data, 5 stream
  int          m_off = 0;
  logic [15:0] m_crc = 16'h0;
  logic [7:0]  m_q [$];

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] v = c;
    for (int i = 0; i < 8; i++) begin
      bit fb = v[0] ^ d[i];
      v = v >> 1;
      if (fb) v = v ^ 16'hA001;
    end
    return v;
  endfunction

  function automatic logic [15:0] ref_norm(input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] a = {1'b0, hi[6:0], lo};
    if (a >= 16'h7FC0 && a <= 16'h7FCF) a[2:0] = 3'b000;
    return a;
  endfunction

  function automatic void push_crc_tx(input logic [7:0] b);
    m_q.push_back(b);
    m_crc = ref_crc(m_crc, b);
  endfunction

  function automatic void model_rx(input logic [7:0] b);
    case (m_mode)
      0: begin
        if (b == 8'h0F) begin
          m_es[7:6] = 2'b00; m_crc = ref_crc(16'h0, b); m_mode = 2;
        end else if (b == 8'hAA) begin
          m_crc = ref_crc(16'h0, b);
          push_crc_tx(m_ta[7:0]);
          push_crc_tx(m_ta[15:8]);
          push_crc_tx(m_es);
          for (int i = int'(m_ta[5:0]); i < 64; i++) push_crc_tx(m_mem[i]);
          m_q.push_back(~m_crc[7:0]);
          m_q.push_back(~m_crc[15:8]);
          m_mode = 5;
        end else m_mode = 1;
      end
      2: begin m_ta1 = b; m_crc = ref_crc(m_crc, b); m_mode = 3; end
      3: begin
        m_ta = ref_norm(m_ta1, b); m_off = int'(m_ta[5:0]);
        m_es[5:0] = m_ta[5:0]; m_crc = ref_crc(m_crc, b); m_mode = 4;
      end
      4: begin
        m_mem[m_off] = b; m_vld[m_off] = 1; m_es[5:0] = 6'(m_off);
        m_crc = ref_crc(m_crc, b);
        if (m_off == 63) begin
          m_q.push_back(~m_crc[7:0]); m_q.push_back(~m_crc[15:8]); m_mode = 5;
        end else m_off++;
      end
      default: ;
    endcase
  endfunction

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      logic [7:0] exp_tx;
      exp_tx = (m_q.size() > 0) ? m_q[0] : 8'hFF;
      vectors++;
      if (ta_out !== m_ta) begin
        fails++; $display("FAIL R2 ta_out got %h exp %h", ta_out, m_ta);
      end
      if (es_out !== m_es) begin
        fails++; $display("FAIL R4 es_out got %h exp %h", es_out, m_es);
      end
      if (tx_byte !== exp_tx) begin
        fails++; $display("FAIL R6/R7 tx_byte got %h exp %h", tx_byte, exp_tx);
      end
      if (m_vld[cp_addr] && cp_data !== m_mem[cp_addr]) begin
        fails++; $display("FAIL R11 cp_data[%0d] got %h exp %h", cp_addr, cp_data, m_mem[cp_addr]);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++; $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; tick(); rx_valid = 1'b0; model_rx(b);
  endtask

  task automatic send_partial();
    rx_partial = 1'b1; tick(); rx_partial = 1'b0;
    if (m_mode >= 2 && m_mode <= 4) m_es[6] = 1'b1;
    if (m_mode <= 4) m_mode = 1;
  endtask

  task automatic pull(input int n);
    for (int i = 0; i < n; i++) begin
      tx_req = 1'b1; tick(); tx_req = 1'b0;
      if (m_mode == 5 && m_q.size() > 0) void'(m_q.pop_front());
    end
  endtask

  task automatic frame();
    frame_start = 1'b1; tick(); frame_start = 1'b0; m_mode = 0; m_q.delete();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_vld[i] = 0;
    #1 rst_n = 1'b0;
    armed = 1;
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R1: reset values
    chk("R1 ta", ta_out, 16'h0000);
    chk("R1 es", {8'h0, es_out}, 16'h0000);
    chk("R1 tx", {8'h0, tx_byte}, 16'h00FF);

    // R4 R6: full-page write from address 1000h
    send(8'h0F); send(8'h00); send(8'h10);
    chk("R4 start offset", {8'h0, es_out}, 16'h0000);
    for (int i = 0; i < 64; i++) send(8'((i * 37 + 5) & 8'hFF));
    chk("R4 ending 3F", {8'h0, es_out}, 16'h003F);
    send(8'h77);                        // R4: ignored after offset 3Fh
    pull(3);                            // R6: inverted CRC then FF

    // R7: read back the whole page
    frame(); send(8'hAA); pull(64 + 6);

    // R2 R4: address above user range, mid-page start
    frame(); send(8'h0F); send(8'h3C); send(8'h90);
    chk("R2 msb cleared", ta_out, 16'h103C);
    send(8'hA1); send(8'hB2); send(8'hC3); send(8'hD4);
    chk("R4 four bytes fill", {8'h0, es_out}, 16'h003F);
    pull(3);
    frame(); send(8'hAA); pull(10);     // R7: short stream from offset 3Ch

    // R9 then R2 R5 R6
    aa_set = 1'b1; tick(); aa_set = 1'b0; m_es[7] = 1'b1;
    chk("R9 AA set", {15'h0, es_out[7]}, 16'h0001);
    frame(); send(8'h0F);
    chk("R2 flags cleared", {14'h0, es_out[7:6]}, 16'h0000);
    send(8'h05); send(8'h00); send(8'h11); send(8'h22);
    pull(1);                            // R6: no CRC before offset 3Fh
    chk("R6 no crc early", {8'h0, tx_byte}, 16'h00FF);
    send_partial();
    chk("R5 PF and end", {8'h0, es_out}, 16'h0046);
    send(8'h99);                        // R5: discarded
    cp_addr = 6'd7; tick();
    chk("R5 byte discarded", {8'h0, cp_data}, {8'h0, m_mem[7]});

    // R3: password window start
    frame(); send(8'h0F); send(8'hCB); send(8'hFF);
    chk("R3 aligned", ta_out, 16'h7FC8);
    for (int i = 0; i < 8; i++) send(8'h30 + 8'(i));
    chk("R3 ending 0F", {8'h0, es_out}, 16'h000F);
    frame(); send(8'hAA); pull(8);

    // R8: power loss
    pwr_lost = 1'b1; tick(); pwr_lost = 1'b0; m_es[6] = 1'b1;
    chk("R8 PF set", {15'h0, es_out[6]}, 16'h0001);
    frame(); send(8'hAA); pull(64);

    // R10: unknown command, then abort mid-write
    frame(); send(8'h55); send(8'h0F); send(8'h12); pull(2);
    chk("R10 inert tx", {8'h0, tx_byte}, 16'h00FF);
    chk("R10 ta unchanged", ta_out, 16'h7FC8);
    frame(); send(8'h0F); send(8'h20); send(8'h00); send(8'h5A);
    frame(); send(8'hAA); pull(40);

    // R11: copy port sweep
    for (int i = 0; i < 64; i += 5) begin
      cp_addr = 6'(i); tick();
      chk("R11 cp_data", {8'h0, cp_data}, {8'h0, m_mem[i]});
    end

    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule